// File: doc/BRIEF.md
# Multi-Token Dataflow Actor Sequencer

This block is a hardware dataflow actor whose single action needs a whole pattern of tokens: two from the first input stream, three from the second and one from the third. It produces one token on the first output stream and two on the second. Each input stream is a valid/ready channel that moves one token per transfer. Each input has a small ring buffer that keeps accepting tokens as long as it has room, whatever the sequencer is doing.

A four-state sequencer gathers the pattern and computes the results. It starts in a rest state and moves to a gathering loop at once. It leaves that loop as soon as every buffer holds its required count. It spends one cycle on the arithmetic and consumes the pattern from the buffers. It then sends the three result tokens one at a time and returns to rest after the last one is taken. Tokens that arrive beyond the current pattern stay in their buffers, in arrival order, for the next firing.

Top module: `multitoken_actor`

## Requirements
- R1: While reset is high, all three input ready outputs and both output valid outputs are low. After reset is released the actor holds no tokens and drives no output valid until a full pattern has been gathered.
- R2: Each input's ready is high exactly when reset is low and the number of accepted tokens not yet consumed on that input is below that input's depth. The depths are 2, 4 and 1 for inputs 1, 2 and 3.
- R3: Input acceptance does not depend on the sequencer state. Tokens are taken during the processing cycle and while results are being sent whenever buffer room exists.
- R4: A firing starts only once input 1 holds at least 2 tokens, input 2 at least 3 and input 3 at least 1. A partial pattern produces no output.
- R5: A firing consumes the oldest tokens, a0 and a1 from input 1, b0, b1 and b2 from input 2, and c0 from input 3. It outputs out1 = a0+a1+c0, out2 first = b0+b1 and out2 second = b2-c0, all as 16-bit values that wrap around.
- R6: Results leave in a fixed order: the out1 token, then the first out2 token, then the second out2 token. The two output valids are never high together.
- R7: An output token whose valid is high while its ready is low keeps its valid high and its data unchanged in the next cycle.
- R8: Tokens beyond the current pattern stay buffered in arrival order. Every accepted token is used by exactly one firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in1Data | input | 16 | Input 1 token |
| in1Valid | input | 1 | Input 1 token present |
| in1Ready | output | 1 | Input 1 buffer has room |
| in2Data | input | 16 | Input 2 token |
| in2Valid | input | 1 | Input 2 token present |
| in2Ready | output | 1 | Input 2 buffer has room |
| in3Data | input | 16 | Input 3 token |
| in3Valid | input | 1 | Input 3 token present |
| in3Ready | output | 1 | Input 3 buffer has room |
| out1Data | output | 16 | Output 1 token |
| out1Valid | output | 1 | Output 1 token present |
| out1Ready | input | 1 | Output 1 consumer takes the token |
| out2Data | output | 16 | Output 2 token |
| out2Valid | output | 1 | Output 2 token present |
| out2Ready | input | 1 | Output 2 consumer takes the token |

## Verification
The hardest situation to reach from the ports is a token being accepted while the sequencer sits in its result-sending state. This needs one input buffer to be full of surplus tokens exactly when a firing frees room. A directed opening sequence reaches it: it fills input 2 to its depth of four with both outputs stalled, then completes the pattern, so the fifth token enters during the stalled send. The same sequence uses wrap-around operands and leaves a partial pattern behind to show that no output follows. A long random phase with stalls on both sides then compares every result against a queue model, and checks each ready against a modelled occupancy in every cycle.

// File: rtl/actor_pkg.sv
package actor_pkg;
  localparam int IN1_TAKE   = 2;
  localparam int IN2_TAKE   = 3;
  localparam int IN3_TAKE   = 1;
  localparam int OUT_TOKENS = 3;

  function automatic int pow2AtLeast(int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  localparam int IN1_DEPTH = pow2AtLeast(IN1_TAKE);
  localparam int IN2_DEPTH = pow2AtLeast(IN2_TAKE);
  localparam int IN3_DEPTH = pow2AtLeast(IN3_TAKE);
  localparam int SLOT_W    = $clog2(OUT_TOKENS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_PROC,
    ST_WRITE
  } actorState_t;

  typedef struct packed {
    logic              fire;
    logic              emit;
    logic [SLOT_W-1:0] slot;
  } strobes_t;
endpackage

// File: rtl/token_buffer.sv
module token_buffer #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  parameter int TAKE  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          pushData,
  input  logic                  pushValid,
  output logic                  pushReady,
  input  logic                  pop,
  output logic [TAKE-1:0][W-1:0] peek,
  output logic                  enough
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW    = AW + 1;
  localparam int SLOTS = 1 << AW;

  logic [W-1:0]  mem [SLOTS];
  logic [PW-1:0] wPtr, rPtr, fill;

  assign fill      = wPtr - rPtr;
  assign pushReady = !rst && (fill < PW'(DEPTH));
  assign enough    = fill >= PW'(TAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      if (pushValid && pushReady) wPtr <= wPtr + 1'b1;
      if (pop) rPtr <= rPtr + PW'(TAKE);
    end
  end

  always_ff @(posedge clk) begin
    if (pushValid && pushReady) mem[wPtr[AW-1:0]] <= pushData;
  end

  for (genvar k = 0; k < TAKE; k++) begin : g_peek
    logic [PW-1:0] at;
    assign at      = rPtr + PW'(k);
    assign peek[k] = mem[at[AW-1:0]];
  end
endmodule

// File: rtl/actor_datapath.sv
module actor_datapath
  import actor_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in1Data,
  input  logic         in1Valid,
  output logic         in1Ready,
  input  logic [W-1:0] in2Data,
  input  logic         in2Valid,
  output logic         in2Ready,
  input  logic [W-1:0] in3Data,
  input  logic         in3Valid,
  output logic         in3Ready,
  output logic [W-1:0] out1Data,
  output logic         out1Valid,
  input  logic         out1Ready,
  output logic [W-1:0] out2Data,
  output logic         out2Valid,
  input  logic         out2Ready,
  input  strobes_t     strobes,
  output logic         haveAll,
  output logic         tokenTaken
);
  logic [IN1_TAKE-1:0][W-1:0] pat1;
  logic [IN2_TAKE-1:0][W-1:0] pat2;
  logic [IN3_TAKE-1:0][W-1:0] pat3;
  logic enough1, enough2, enough3;
  logic [W-1:0] res1, res2a, res2b;

  token_buffer #(.W(W), .DEPTH(IN1_DEPTH), .TAKE(IN1_TAKE)) uBuf1 (
    .clk, .rst, .pushData(in1Data), .pushValid(in1Valid), .pushReady(in1Ready),
    .pop(strobes.fire), .peek(pat1), .enough(enough1));
  token_buffer #(.W(W), .DEPTH(IN2_DEPTH), .TAKE(IN2_TAKE)) uBuf2 (
    .clk, .rst, .pushData(in2Data), .pushValid(in2Valid), .pushReady(in2Ready),
    .pop(strobes.fire), .peek(pat2), .enough(enough2));
  token_buffer #(.W(W), .DEPTH(IN3_DEPTH), .TAKE(IN3_TAKE)) uBuf3 (
    .clk, .rst, .pushData(in3Data), .pushValid(in3Valid), .pushReady(in3Ready),
    .pop(strobes.fire), .peek(pat3), .enough(enough3));

  assign haveAll = enough1 && enough2 && enough3;

  always_ff @(posedge clk) begin
    if (rst) begin
      res1  <= '0;
      res2a <= '0;
      res2b <= '0;
    end else if (strobes.fire) begin
      res1  <= pat1[0] + pat1[1] + pat3[0];
      res2a <= pat2[0] + pat2[1];
      res2b <= pat2[2] - pat3[0];
    end
  end

  assign out1Data   = res1;
  assign out2Data   = (strobes.slot == SLOT_W'(1)) ? res2a : res2b;
  assign out1Valid  = strobes.emit && (strobes.slot == '0);
  assign out2Valid  = strobes.emit && (strobes.slot != '0);
  assign tokenTaken = (out1Valid && out1Ready) || (out2Valid && out2Ready);
endmodule

// File: rtl/actor_control.sv
module actor_control
  import actor_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     haveAll,
  input  logic     tokenTaken,
  output strobes_t strobes
);
  actorState_t       state;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      slot  <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  state <= ST_READ;
        ST_READ:  if (haveAll) state <= ST_PROC;
        ST_PROC: begin
          state <= ST_WRITE;
          slot  <= '0;
        end
        ST_WRITE: if (tokenTaken) begin
          if (slot == SLOT_W'(OUT_TOKENS - 1)) begin
            state <= ST_IDLE;
            slot  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobes.fire = (state == ST_PROC);
  assign strobes.emit = (state == ST_WRITE);
  assign strobes.slot = slot;
endmodule

// File: rtl/multitoken_actor.sv
module multitoken_actor
  import actor_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in1Data,
  input  logic              in1Valid,
  output logic              in1Ready,
  input  logic [DATA_W-1:0] in2Data,
  input  logic              in2Valid,
  output logic              in2Ready,
  input  logic [DATA_W-1:0] in3Data,
  input  logic              in3Valid,
  output logic              in3Ready,
  output logic [DATA_W-1:0] out1Data,
  output logic              out1Valid,
  input  logic              out1Ready,
  output logic [DATA_W-1:0] out2Data,
  output logic              out2Valid,
  input  logic              out2Ready
);
  strobes_t strobes;
  logic     haveAll, tokenTaken;

  actor_control uCtrl (
    .clk, .rst, .haveAll, .tokenTaken, .strobes);

  actor_datapath #(.W(DATA_W)) uPath (
    .clk, .rst,
    .in1Data, .in1Valid, .in1Ready,
    .in2Data, .in2Valid, .in2Ready,
    .in3Data, .in3Valid, .in3Ready,
    .out1Data, .out1Valid, .out1Ready,
    .out2Data, .out2Valid, .out2Ready,
    .strobes, .haveAll, .tokenTaken);
endmodule

// File: rtl/actor_chk.sv
module actor_chk
  import actor_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in1Valid,
  input logic              in1Ready,
  input logic              in2Valid,
  input logic              in2Ready,
  input logic              in3Valid,
  input logic              in3Ready,
  input logic [DATA_W-1:0] out1Data,
  input logic              out1Valid,
  input logic              out1Ready,
  input logic [DATA_W-1:0] out2Data,
  input logic              out2Valid,
  input logic              out2Ready,
  input logic              fire
);
  logic [3:0] occ1, occ2, occ3;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ1 <= '0;
      occ2 <= '0;
      occ3 <= '0;
    end else begin
      occ1 <= occ1 + 4'(in1Valid && in1Ready) - (fire ? 4'(IN1_TAKE) : 4'd0);
      occ2 <= occ2 + 4'(in2Valid && in2Ready) - (fire ? 4'(IN2_TAKE) : 4'd0);
      occ3 <= occ3 + 4'(in3Valid && in3Ready) - (fire ? 4'(IN3_TAKE) : 4'd0);
    end
  end

  // R1
  reset_ready_chk: assert property (@(posedge clk)
    rst |-> (!in1Ready && !in2Ready && !in3Ready));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out1Valid && !out2Valid));
  // R2
  in1_room_chk: assert property (@(posedge clk) disable iff (rst)
    occ1 <= 4'(IN1_DEPTH));
  // R2
  in2_room_chk: assert property (@(posedge clk) disable iff (rst)
    occ2 <= 4'(IN2_DEPTH));
  // R2
  in3_room_chk: assert property (@(posedge clk) disable iff (rst)
    occ3 <= 4'(IN3_DEPTH));
  // R4
  fire_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> (occ1 >= 4'(IN1_TAKE) && occ2 >= 4'(IN2_TAKE) && occ3 >= 4'(IN3_TAKE)));
  // R6
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(out1Valid && out2Valid));
  // R7
  out1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out1Valid && !out1Ready) |=> (out1Valid && $stable(out1Data)));
  // R7
  out2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out2Valid && !out2Ready) |=> (out2Valid && $stable(out2Data)));
endmodule

bind multitoken_actor actor_chk #(.DATA_W(DATA_W)) uChk (
  .clk, .rst,
  .in1Valid, .in1Ready, .in2Valid, .in2Ready, .in3Valid, .in3Ready,
  .out1Data, .out1Valid, .out1Ready, .out2Data, .out2Valid, .out2Ready,
  .fire(strobes.fire));

// File: tb/tb_multitoken_actor.sv
`timescale 1ns/1ps
module tb_multitoken_actor;
  localparam int K = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] inData [3];
  logic [2:0]  inValid;
  logic [2:0]  inReady;
  logic [15:0] out1Data, out2Data;
  logic out1Valid, out2Valid, out1Ready, out2Ready;

  always #4 clk = ~clk;

  multitoken_actor dut (
    .clk, .rst,
    .in1Data(inData[0]), .in1Valid(inValid[0]), .in1Ready(inReady[0]),
    .in2Data(inData[1]), .in2Valid(inValid[1]), .in2Ready(inReady[1]),
    .in3Data(inData[2]), .in3Valid(inValid[2]), .in3Ready(inReady[2]),
    .out1Data, .out1Valid, .out1Ready,
    .out2Data, .out2Valid, .out2Ready);

  int checks = 0, errors = 0;
  int need [3]  = '{2, 3, 1};
  int depth [3] = '{2, 4, 1};
  int budget [3], prob [3], acc [3];
  int outProb;
  bit pend [3];
  logic [15:0] preset [3][$];
  logic [15:0] got [3][$];
  logic [15:0] exp [3];
  int outCount = 0, firings = 0;
  bit inFiring = 0;
  bit hold1 = 0, hold2 = 0;
  logic [15:0] held1, held2;
  bit done = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic score(int port, logic [15:0] data);
    int pos;
    pos = outCount % 3;
    check(port == (pos == 0 ? 0 : 1), "R6", "output port order", port, (pos == 0 ? 0 : 1));
    if (pos == 0) begin
      if (got[0].size() < 2 || got[1].size() < 3 || got[2].size() < 1) begin
        check(0, "R4", "firing without full pattern", got[1].size(), 3);
        exp = '{16'h0, 16'h0, 16'h0};
      end else begin
        logic [15:0] a0, a1, b0, b1, b2, c0;
        a0 = got[0].pop_front(); a1 = got[0].pop_front();
        b0 = got[1].pop_front(); b1 = got[1].pop_front(); b2 = got[1].pop_front();
        c0 = got[2].pop_front();
        exp[0] = a0 + a1 + c0;
        exp[1] = b0 + b1;
        exp[2] = b2 - c0;
      end
    end
    check(data == exp[pos], "R5", "output value", data, exp[pos]);
    outCount++;
    if (pos == 2) inFiring = 0;
  endtask

  task automatic step();
    bit r1, r2;
    @(negedge clk);
    if (out1Valid && !inFiring) begin
      inFiring = 1;
      firings++;
    end
    check(!(out1Valid && out2Valid), "R6", "both output valids high", {out1Valid, out2Valid}, 0);
    if (hold1) check(out1Valid && out1Data == held1, "R7", "out1 hold", out1Data, held1);
    if (hold2) check(out2Valid && out2Data == held2, "R7", "out2 hold", out2Data, held2);
    for (int p = 0; p < 3; p++) begin
      int occ;
      bit expRdy;
      occ = acc[p] - need[p] * firings;
      expRdy = !rst && (occ < depth[p]);
      check(inReady[p] == expRdy, "R2", $sformatf("in%0d ready vs room", p + 1), inReady[p], expRdy);
    end
    for (int p = 0; p < 3; p++) begin
      if (!pend[p] && budget[p] > 0 && $urandom_range(99) < prob[p]) begin
        pend[p] = 1;
        budget[p]--;
        inData[p] = (preset[p].size() > 0) ? preset[p].pop_front() : 16'($urandom);
      end
      inValid[p] = pend[p];
    end
    r1 = $urandom_range(99) < outProb;
    r2 = $urandom_range(99) < outProb;
    out1Ready = r1;
    out2Ready = r2;
    for (int p = 0; p < 3; p++) begin
      if (pend[p] && inReady[p]) begin
        got[p].push_back(inData[p]);
        acc[p]++;
        pend[p] = 0;
      end
    end
    if (out1Valid && r1) score(0, out1Data);
    if (out2Valid && r2) score(1, out2Data);
    hold1 = out1Valid && !r1; held1 = out1Data;
    hold2 = out2Valid && !r2; held2 = out2Data;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", outCount, 3 * (K + 1));
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    inValid = '0;
    out1Ready = 0; out2Ready = 0;
    for (int p = 0; p < 3; p++) begin
      inData[p] = '0; budget[p] = 0; prob[p] = 100; acc[p] = 0; pend[p] = 0;
    end
    outProb = 0;
    // R1: reset state
    repeat (3) step();
    check(inReady == 3'b000, "R1", "readies in reset", inReady, 0);
    check(!out1Valid && !out2Valid, "R1", "valids in reset", {out1Valid, out2Valid}, 0);
    rst = 0;
    step();
    check(!out1Valid && !out2Valid, "R1", "valids after reset", {out1Valid, out2Valid}, 0);

    // R2: fill input 2 beyond depth with outputs stalled
    preset[0] = '{16'hFFFF, 16'hFFFF};
    preset[1] = '{16'h0001, 16'h0002, 16'h0001, 16'h0007, 16'h0009};
    preset[2] = '{16'h0003};
    budget[1] = 5;
    repeat (10) step();
    check(acc[1] == 4, "R2", "input 2 tokens taken at depth", acc[1], 4);
    check(inReady[1] == 0, "R2", "input 2 ready when full", inReady[1], 0);
    check(outCount == 0 && !out1Valid, "R4", "no output before pattern", outCount, 0);

    // complete the pattern with wrap-around operands
    budget[0] = 2; budget[2] = 1;
    for (int i = 0; i < 20 && !out1Valid; i++) step();
    check(out1Valid, "R4", "firing after full pattern", out1Valid, 1);
    check(out1Data == 16'h0001, "R5", "wrapped out1 sum", out1Data, 16'h0001);
    repeat (4) step();
    // R3: fifth token accepted while results are pending
    check(acc[1] == 5 && out1Valid, "R3", "accept during send", acc[1], 5);
    outProb = 100;
    repeat (8) step();
    check(outCount == 3, "R6", "three results sent", outCount, 3);

    // R4: partial pattern (two input 2 tokens left) yields nothing
    repeat (10) step();
    check(outCount == 3 && !out1Valid && !out2Valid, "R4", "partial pattern silent", outCount, 3);
    check(got[1].size() == 2, "R8", "surplus tokens retained", got[1].size(), 2);

    // random phase with stalls on both sides
    budget[0] = 2 * K; budget[1] = 3 * K - 2; budget[2] = K;
    prob[0] = 60; prob[1] = 55; prob[2] = 45;
    outProb = 70;
    for (int i = 0; i < 60000 && outCount < 3 * (K + 1); i++) step();
    check(outCount == 3 * (K + 1), "R8", "all firings completed", outCount, 3 * (K + 1));
    check(got[0].size() == 0 && got[1].size() == 0 && got[2].size() == 0,
          "R8", "every token used once", got[1].size(), 0);
    done = 1;
    summary();
  end
endmodule